// File: doc/BRIEF.md
# Store Miss Merging Buffer

This block sits between a load/store unit and the bus interface below it. It takes store misses that are aimed at 32-byte lines and keeps one entry per missing line. Any later store to a line that is still waiting for its bus request is folded into the same entry. Each entry holds a byte-valid mask, and the stored bytes are written into a line-wide data register.

When its request is offered, an entry whose mask covers every byte asks only for ownership of the line. This is an address-only claim, and no data comes back. An entry with gaps in its mask instead asks for a read with intent to modify. The fill that returns is written only into the bytes the stores did not touch. Up to eight lines can be in flight at once. Every request carries its entry index as a tag, so responses can arrive in any order. A finished line is presented on the completion port for one cycle, after which its entry is freed.

Top module: `store_merge_buf`

## Requirements
- R1: After reset, st_ready is 1, bus_req_valid is 0 and done_valid is 0.
- R2: A store whose line address matches an entry that has not yet been granted is merged into that entry. The mask is ORed with st_be and the enabled bytes are overwritten, so the later store wins on overlap. The line then produces exactly one bus request.
- R3: If the offered entry's mask is all ones, bus_req_type is 1 (address-only claim). On grant, the line completes on the next cycle without any response, carrying the stored bytes.
- R4: If the offered entry's mask has any zero bit, bus_req_type is 0 (read with intent to modify). The response data replaces only the bytes whose mask bit is 0, and done_data carries the merged line.
- R5: A store to a line with no matching ungranted entry is placed in the lowest-index free entry. That index is the tag of its bus request and of its completion, and done_line returns the line address.
- R6: st_ready is 0 only when no entry is free and no ungranted entry matches st_line. A store to such a matching line is still accepted when all eight entries are occupied.
- R7: Responses may arrive in any order and are matched to entries by rsp_tag. A response whose tag names no entry that is waiting for data has no effect.
- R8: Once an entry's request has been granted, no more stores merge into it. A later store to the same line allocates a new entry and issues a new request.
- R9: done_valid rises one cycle after the response or the address-only grant. When several entries are ready to complete, they leave one per cycle, lowest index first.
- R10: bus_req_valid is 1 whenever any entry has not yet been granted. The offered request is the lowest-index such entry, and bus_req_tag, bus_req_line and bus_req_type all belong to that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store miss present |
| st_ready | output | 1 | Store accepted this cycle |
| st_line | input | LINE_AW | Line address of the store |
| st_be | input | LINE_BYTES | Byte enables within the line |
| st_data | input | LINE_BYTES*8 | Store data, line aligned |
| bus_req_valid | output | 1 | Bus request offered |
| bus_req_ready | input | 1 | Bus grant for the offered request |
| bus_req_type | output | 1 | 1 = address-only claim, 0 = read with intent to modify |
| bus_req_tag | output | log2(NUM_ENT) | Entry index of the request |
| bus_req_line | output | LINE_AW | Line address of the request |
| rsp_valid | input | 1 | Fill response present |
| rsp_tag | input | log2(NUM_ENT) | Tag of the response |
| rsp_data | input | LINE_BYTES*8 | Fill data for the line |
| done_valid | output | 1 | Completed line present |
| done_tag | output | log2(NUM_ENT) | Entry index of the completed line |
| done_line | output | LINE_AW | Line address of the completed line |
| done_data | output | LINE_BYTES*8 | Merged line contents |

## Verification
The bench targets the following corner cases:

- **Overlapping merges.** If the merge order were wrong, the bytes written by the earlier store would survive where the later store overlaps them.
- **Fill writing over store data.** A fill that ignored the mask would overwrite bytes the stores had written.
- **Unnecessary data transfer.** A line covered by several partial stores that was still sent as a read would cost a data transfer that is not needed.
- **Eight-entry limit.** It fills all eight entries, then checks that a store to a new line stalls while a store to a pending line still goes through.
- **Shuffled and stray responses.** It returns responses in a shuffled order and sends one stray response. Wrong tag matching would complete the wrong line, or complete a line that never received its data.
- **Store after grant.** It stores to a line after that line's grant. A design that still merged there would lose the store from the request already in flight.
- **Two completions in one cycle.** It makes a claim grant and a response land in the same cycle. A design without a completion order would drop one line or present two at once.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [1:0] {
    ENT_IDLE = 2'd0,
    ENT_OPEN = 2'd1,
    ENT_WAIT = 2'd2,
    ENT_RET  = 2'd3
  } ent_state_e;

  localparam logic REQ_RWITM = 1'b0;
  localparam logic REQ_CLAIM = 1'b1;

endpackage

// File: rtl/smb_ffs.sv
module smb_ffs #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  oh_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);

  always_comb begin
    oh_o  = '0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        oh_o    = '0;
        oh_o[i] = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end

  assign any_o = |req_i;

endmodule

// File: rtl/smb_entry.sv
module smb_entry
  import smb_pkg::*;
#(
  parameter int LINE_BYTES = 32,
  parameter int LINE_AW    = 27,
  localparam int DATA_W    = LINE_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  alloc_i,
  input  logic                  merge_i,
  input  logic                  grant_i,
  input  logic                  fill_i,
  input  logic                  retire_i,
  input  logic [LINE_AW-1:0]    wr_line_i,
  input  logic [LINE_BYTES-1:0] wr_be_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic [DATA_W-1:0]     fill_data_i,
  output ent_state_e            state_o,
  output logic [LINE_AW-1:0]    line_o,
  output logic [LINE_BYTES-1:0] mask_o,
  output logic [DATA_W-1:0]     data_o,
  output logic                  full_o
);

  ent_state_e            state_q;
  logic [LINE_AW-1:0]    line_q;
  logic [LINE_BYTES-1:0] mask_q;
  logic [DATA_W-1:0]     data_q;
  logic [LINE_BYTES-1:0] wr_en;
  logic [LINE_BYTES-1:0] fill_en;

  assign wr_en   = (alloc_i || merge_i) ? wr_be_i : '0;
  assign fill_en = fill_i ? ~mask_q : '0;
  assign full_o  = &mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ENT_IDLE;
      mask_q  <= '0;
    end else begin
      case (state_q)
        ENT_IDLE: begin
          if (alloc_i) begin
            state_q <= ENT_OPEN;
            mask_q  <= wr_be_i;
          end
        end
        ENT_OPEN: begin
          if (merge_i) mask_q <= mask_q | wr_be_i;
          if (grant_i) state_q <= full_o ? ENT_RET : ENT_WAIT;
        end
        ENT_WAIT: begin
          if (fill_i) state_q <= ENT_RET;
        end
        default: begin
          if (retire_i) state_q <= ENT_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_i) line_q <= wr_line_i;
  end

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (wr_en[b])        data_q[b*8 +: 8] <= wr_data_i[b*8 +: 8];
      else if (fill_en[b]) data_q[b*8 +: 8] <= fill_data_i[b*8 +: 8];
    end
  end

  assign state_o = state_q;
  assign line_o  = line_q;
  assign mask_o  = mask_q;
  assign data_o  = data_q;

endmodule

// File: rtl/store_merge_buf.sv
module store_merge_buf
  import smb_pkg::*;
#(
  parameter int NUM_ENT    = 8,
  parameter int LINE_BYTES = 32,
  parameter int LINE_AW    = 27,
  localparam int DATA_W    = LINE_BYTES * 8,
  localparam int TAG_W     = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  st_valid,
  output logic                  st_ready,
  input  logic [LINE_AW-1:0]    st_line,
  input  logic [LINE_BYTES-1:0] st_be,
  input  logic [DATA_W-1:0]     st_data,
  output logic                  bus_req_valid,
  input  logic                  bus_req_ready,
  output logic                  bus_req_type,
  output logic [TAG_W-1:0]      bus_req_tag,
  output logic [LINE_AW-1:0]    bus_req_line,
  input  logic                  rsp_valid,
  input  logic [TAG_W-1:0]      rsp_tag,
  input  logic [DATA_W-1:0]     rsp_data,
  output logic                  done_valid,
  output logic [TAG_W-1:0]      done_tag,
  output logic [LINE_AW-1:0]    done_line,
  output logic [DATA_W-1:0]     done_data
);

  ent_state_e            state_a [NUM_ENT];
  logic [LINE_AW-1:0]    line_a  [NUM_ENT];
  logic [LINE_BYTES-1:0] mask_a  [NUM_ENT];
  logic [DATA_W-1:0]     data_a  [NUM_ENT];
  logic [NUM_ENT-1:0]    full_vec;

  logic [NUM_ENT-1:0] idle_vec, open_vec, wait_vec, ret_vec, match_vec;
  logic [NUM_ENT-1:0] alloc_oh, req_oh, ret_oh;
  logic [TAG_W-1:0]   alloc_idx, req_idx, ret_idx;
  logic               any_idle, any_open, any_ret;
  logic               hit, st_fire, grant;

  smb_ffs #(.N(NUM_ENT)) u_alloc_pick (
    .req_i(idle_vec), .oh_o(alloc_oh), .idx_o(alloc_idx), .any_o(any_idle)
  );
  smb_ffs #(.N(NUM_ENT)) u_req_pick (
    .req_i(open_vec), .oh_o(req_oh), .idx_o(req_idx), .any_o(any_open)
  );
  smb_ffs #(.N(NUM_ENT)) u_ret_pick (
    .req_i(ret_vec), .oh_o(ret_oh), .idx_o(ret_idx), .any_o(any_ret)
  );

  assign hit      = |match_vec;
  assign st_ready = hit || any_idle;
  assign st_fire  = st_valid && st_ready;
  assign grant    = any_open && bus_req_ready;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    logic alloc_g, merge_g, grant_g, fill_g;

    assign idle_vec[g]  = (state_a[g] == ENT_IDLE);
    assign open_vec[g]  = (state_a[g] == ENT_OPEN);
    assign wait_vec[g]  = (state_a[g] == ENT_WAIT);
    assign ret_vec[g]   = (state_a[g] == ENT_RET);
    assign match_vec[g] = open_vec[g] && (line_a[g] == st_line);

    assign alloc_g = st_fire && !hit && alloc_oh[g];
    assign merge_g = st_fire && match_vec[g];
    assign grant_g = grant && req_oh[g];
    assign fill_g  = rsp_valid && (rsp_tag == TAG_W'(g)) && wait_vec[g];

    smb_entry #(.LINE_BYTES(LINE_BYTES), .LINE_AW(LINE_AW)) u_entry (
      .clk        (clk),
      .rst        (rst),
      .alloc_i    (alloc_g),
      .merge_i    (merge_g),
      .grant_i    (grant_g),
      .fill_i     (fill_g),
      .retire_i   (ret_oh[g]),
      .wr_line_i  (st_line),
      .wr_be_i    (st_be),
      .wr_data_i  (st_data),
      .fill_data_i(rsp_data),
      .state_o    (state_a[g]),
      .line_o     (line_a[g]),
      .mask_o     (mask_a[g]),
      .data_o     (data_a[g]),
      .full_o     (full_vec[g])
    );
  end

  assign bus_req_valid = any_open;
  assign bus_req_tag   = req_idx;
  assign bus_req_line  = line_a[req_idx];
  assign bus_req_type  = full_vec[req_idx] ? REQ_CLAIM : REQ_RWITM;

  assign done_valid = any_ret;
  assign done_tag   = ret_idx;
  assign done_line  = line_a[ret_idx];
  assign done_data  = data_a[ret_idx];

endmodule

// File: rtl/smb_checker.sv
module smb_checker #(
  parameter int NUM_ENT = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               st_ready,
  input logic               bus_req_valid,
  input logic               bus_req_ready,
  input logic               bus_req_type,
  input logic               done_valid,
  input logic [NUM_ENT-1:0] match_vec
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (st_ready && !bus_req_valid && !done_valid)); // R1

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_vec)); // R2

  AST_CLAIM_COMPLETES: assert property (@(posedge clk) disable iff (rst)
    (bus_req_valid && bus_req_ready && bus_req_type) |=> done_valid); // R3

  AST_FREE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> st_ready); // R6

  AST_REQ_PERSISTS: assert property (@(posedge clk) disable iff (rst)
    (bus_req_valid && !bus_req_ready) |=> bus_req_valid); // R10

endmodule

bind store_merge_buf smb_checker #(.NUM_ENT(NUM_ENT)) u_smb_checker (
  .clk          (clk),
  .rst          (rst),
  .st_ready     (st_ready),
  .bus_req_valid(bus_req_valid),
  .bus_req_ready(bus_req_ready),
  .bus_req_type (bus_req_type),
  .done_valid   (done_valid),
  .match_vec    (match_vec)
);

// File: tb/store_merge_buf_bench.sv
`timescale 1ns/1ps
module store_merge_buf_bench;
  localparam int NE  = 8;
  localparam int LB  = 32;
  localparam int LAW = 27;
  localparam int DW  = LB * 8;
  localparam int TW  = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst;
  logic           st_valid, st_ready;
  logic [LAW-1:0] st_line;
  logic [LB-1:0]  st_be;
  logic [DW-1:0]  st_data;
  logic           bus_req_valid, bus_req_ready, bus_req_type;
  logic [TW-1:0]  bus_req_tag;
  logic [LAW-1:0] bus_req_line;
  logic           rsp_valid;
  logic [TW-1:0]  rsp_tag;
  logic [DW-1:0]  rsp_data;
  logic           done_valid;
  logic [TW-1:0]  done_tag;
  logic [LAW-1:0] done_line;
  logic [DW-1:0]  done_data;

  store_merge_buf u_store_merge_buf (
    .clk(clk), .rst(rst),
    .st_valid(st_valid), .st_ready(st_ready), .st_line(st_line),
    .st_be(st_be), .st_data(st_data),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_req_type(bus_req_type), .bus_req_tag(bus_req_tag),
    .bus_req_line(bus_req_line),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
    .done_valid(done_valid), .done_tag(done_tag), .done_line(done_line),
    .done_data(done_data)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference model: 0 free, 1 collecting, 2 awaiting data, 3 completing
  int             ms [NE];
  logic [LAW-1:0] ml [NE];
  logic [LB-1:0]  mm [NE];
  logic [DW-1:0]  md [NE];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cycle();
    int hit, fr, rq, rt, k, t;
    bit e_ready, gnt, fil;
    #1;
    hit = -1; fr = -1; rq = -1; rt = -1;
    for (int i = NE - 1; i >= 0; i--) begin
      if (ms[i] == 1 && ml[i] == st_line) hit = i;
      if (ms[i] == 0) fr = i;
      if (ms[i] == 1) rq = i;
      if (ms[i] == 3) rt = i;
    end
    e_ready = (hit >= 0) || (fr >= 0);
    t = int'(rsp_tag);
    gnt = (rq >= 0) && bus_req_ready;
    fil = rsp_valid && ms[t] == 2;
    if (!rst) begin
      chk(st_ready == e_ready, "R6", "st_ready", DW'(st_ready), DW'(e_ready));
      chk(bus_req_valid == (rq >= 0), "R10", "bus_req_valid",
          DW'(bus_req_valid), DW'(rq >= 0));
      if (rq >= 0 && bus_req_valid) begin
        chk(int'(bus_req_tag) == rq, "R10", "bus_req_tag", DW'(bus_req_tag), DW'(rq));
        chk(bus_req_line == ml[rq], "R10", "bus_req_line", DW'(bus_req_line), DW'(ml[rq]));
        chk(bus_req_type == (mm[rq] == '1), "R3,R4", "bus_req_type",
            DW'(bus_req_type), DW'(mm[rq] == '1));
      end
      chk(done_valid == (rt >= 0), "R9", "done_valid", DW'(done_valid), DW'(rt >= 0));
      if (rt >= 0 && done_valid) begin
        chk(int'(done_tag) == rt, "R9", "done_tag", DW'(done_tag), DW'(rt));
        chk(done_line == ml[rt], "R5", "done_line", DW'(done_line), DW'(ml[rt]));
        chk(done_data == md[rt], "R4", "done_data", done_data, md[rt]);
      end
    end
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < NE; i++) begin ms[i] = 0; mm[i] = '0; end
    end else begin
      if (gnt) ms[rq] = (mm[rq] == '1) ? 3 : 2;
      if (fil) begin
        for (int b = 0; b < LB; b++)
          if (!mm[t][b]) md[t][b*8 +: 8] = rsp_data[b*8 +: 8];
        ms[t] = 3;
      end
      if (rt >= 0) ms[rt] = 0;
      if (st_valid && e_ready) begin
        k = (hit >= 0) ? hit : fr;
        if (hit < 0) begin ms[k] = 1; ml[k] = st_line; mm[k] = '0; end
        mm[k] = mm[k] | st_be;
        for (int b = 0; b < LB; b++)
          if (st_be[b]) md[k][b*8 +: 8] = st_data[b*8 +: 8];
      end
    end
    @(negedge clk);
  endtask

  task automatic put(input logic [LAW-1:0] l, input logic [LB-1:0] be,
                     input logic [DW-1:0] d);
    st_valid = 1'b1; st_line = l; st_be = be; st_data = d;
    cycle();
    st_valid = 1'b0;
  endtask

  task automatic respond(input int tag, input logic [DW-1:0] d);
    rsp_valid = 1'b1; rsp_tag = TW'(tag); rsp_data = d;
    cycle();
    rsp_valid = 1'b0;
  endtask

  task automatic grant_one();
    bus_req_ready = 1'b1;
    cycle();
    bus_req_ready = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] exp1, exp2;
    int ord [NE] = '{5, 2, 7, 0, 3, 6, 1, 4};
    rst = 1'b1; st_valid = 1'b0; st_line = '0; st_be = '0; st_data = '0;
    bus_req_ready = 1'b0; rsp_valid = 1'b0; rsp_tag = '0; rsp_data = '0;
    for (int i = 0; i < NE; i++) begin ms[i] = 0; ml[i] = '0; mm[i] = '0; md[i] = '0; end
    @(negedge clk);
    cycle(); cycle();
    rst = 1'b0;
    #1 chk(st_ready && !bus_req_valid && !done_valid, "R1", "reset outputs",
           DW'({st_ready, bus_req_valid, done_valid}), DW'(3'b100));

    // R2 / R4: two overlapping partial stores, one request, masked fill
    put(27'h10, 32'h0000000F, {8{32'h11111111}});
    put(27'h10, 32'h000000F1, {8{32'h22222222}});
    #1 chk(bus_req_valid && bus_req_tag == 0 && !bus_req_type, "R2", "merged request",
           DW'({bus_req_valid, bus_req_tag, bus_req_type}), DW'(5'b10000));
    grant_one();
    #1 chk(!bus_req_valid, "R2", "no second request", DW'(bus_req_valid), DW'(0));
    respond(0, {8{32'h33333333}});
    exp1 = {{6{32'h33333333}}, 32'h22222222, 32'h11111122};
    #1 chk(done_valid && done_data == exp1, "R4", "merged fill line", done_data, exp1);
    cycle();

    // R3: four partial stores covering the whole line become a claim
    exp2 = '0;
    for (int k = 0; k < 4; k++) begin
      put(27'h20, 32'hFF << (8 * k), {8{32'h40404040 + 32'(k) * 32'h01010101}});
      exp2[64*k +: 64] = {2{32'h40404040 + 32'(k) * 32'h01010101}};
    end
    #1 chk(bus_req_valid && bus_req_type, "R3", "claim type", DW'(bus_req_type), DW'(1));
    grant_one();
    #1 chk(done_valid && done_data == exp2 && !bus_req_valid, "R3", "claim completes",
           done_data, exp2);
    cycle();

    // R6 / R7: fill all entries, stall a new line, accept a pending line
    for (int i = 0; i < NE; i++)
      put(27'h100 + LAW'(i), 32'h3, {8{32'h50000000 + 32'(i)}});
    st_valid = 1'b1; st_line = 27'h200; st_be = 32'h1; st_data = '0;
    #1 chk(!st_ready, "R6", "stall on new line", DW'(st_ready), DW'(0));
    cycle();
    st_line = 27'h103; st_be = 32'h1; st_data = {8{32'h77777777}};
    #1 chk(st_ready, "R6", "accept pending line", DW'(st_ready), DW'(1));
    cycle();
    st_valid = 1'b0;
    respond(3, '0);
    #1 chk(!done_valid, "R7", "stray response ignored", DW'(done_valid), DW'(0));
    bus_req_ready = 1'b1;
    repeat (NE) cycle();
    bus_req_ready = 1'b0;
    for (int j = 0; j < NE; j++) begin
      respond(ord[j], {8{32'h60000000 + 32'(j)}});
      #1 chk(done_valid && int'(done_tag) == ord[j], "R7", "out of order tag",
             DW'(done_tag), DW'(ord[j]));
      cycle();
    end

    // R5 / R8: store after grant allocates a new entry
    put(27'h300, 32'h0000000F, {8{32'h80808080}});
    #1 chk(bus_req_valid && bus_req_tag == 0, "R5", "lowest free entry",
           DW'(bus_req_tag), DW'(0));
    grant_one();
    put(27'h300, 32'h000000F0, {8{32'h90909090}});
    #1 chk(bus_req_valid && bus_req_tag == 1, "R8", "new entry after grant",
           DW'(bus_req_tag), DW'(1));
    grant_one();
    respond(1, {8{32'hAAAAAAAA}});
    cycle();
    respond(0, {8{32'hBBBBBBBB}});
    cycle();

    // R9: claim grant and response in the same cycle
    put(27'h400, 32'h00000001, {8{32'hC0C0C0C0}});
    put(27'h401, 32'hFFFFFFFF, {8{32'hD0D0D0D0}});
    grant_one();
    bus_req_ready = 1'b1;
    rsp_valid = 1'b1; rsp_tag = 3'd0; rsp_data = {8{32'hE0E0E0E0}};
    cycle();
    bus_req_ready = 1'b0; rsp_valid = 1'b0;
    #1 chk(done_valid && done_tag == 0, "R9", "lower index first", DW'(done_tag), DW'(0));
    cycle();
    #1 chk(done_valid && done_tag == 1, "R9", "second completion", DW'(done_tag), DW'(1));
    cycle();
    repeat (3) cycle();

    finished = 1;
    summary();
    $finish;
  end

endmodule